// File: doc/BRIEF.md
# Flash Identification and Query Read Port

This block is the read side of an emulated parallel NOR flash that sits on a 64-bit data path carrying a 32-bit flash bus. A command controller elsewhere decides which read mode is active: plain array data, the status byte, the identification words or the query table. On every read request the block takes the mode, the byte address and the access size, and one cycle later presents a read response. In array mode it forwards the request to an external synchronous memory port and passes the returned word through. In every other mode it answers from its own logic.

Identification and query answers are 16-bit values. The block copies each of them into both halves of a 32-bit access, so the bus behaves like two 16-bit chips placed side by side. Geometry entries of the query table come from the device size parameter: the per-chip size exponent, the erase block count and the per-chip erase block size. The effective erase block is 64 KiB across the two chips.

Top module: `flashq_read_port`

## Requirements
- R1: While no response is being given (rd_valid low), including right after reset, rd_data is all zeros.
- R2: A request sampled at a rising edge produces rd_valid high for exactly the following cycle, and rd_valid is low in every cycle that does not follow a request.
- R3: Mode code 0 (array): mem_req is high in the request cycle with mem_addr equal to rd_addr, and in the response cycle rd_data is mem_rdata with bytes outside the access size forced to zero. mem_req stays low for all other modes.
- R4: Mode code 1 (status): the 16-bit answer is the status_byte sampled in the request cycle, with the upper byte zero.
- R5: Mode code 3 (query): the table index is rd_addr divided by 4. Indexes 0x10, 0x11, 0x12 return 0x51, 0x52, 0x59; indexes 0x31, 0x32, 0x33 return 0x50, 0x52, 0x49; index 0x13 returns 0x01, 0x2A returns 0x06; every index from 0x44 upward returns 0.
- R6: Query geometry: index 0x27 returns log2(DEV_BYTES/2); 0x2D and 0x2E return DEV_BYTES/65536 - 1, low byte at 0x2D; 0x2F and 0x30 return 0x80 and 0x00 (32 KiB per chip in units of 256 bytes).
- R7: Mode code 2 (identification): the entry number is rd_addr[10:2]. Entry 0 returns 0x0000, entry 1 returns 0xFFFF, entry 2 returns lock_bits[rd_addr / 65536] in bit 0, all other entries return 0.
- R8: In non-array modes the answer is placed by size code: 0 (1 byte) in bits 7:0 only, 1 (2 bytes) in bits 15:0, 2 (4 bytes) in bits 15:0 and again in bits 31:16, 3 (8 bytes) as for 4 bytes with bits 63:32 zero.
- R9: A change of rd_mode, rd_addr, status_byte or lock_bits after the request edge does not alter the response already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request for this cycle |
| rd_mode | input | 2 | Read mode: 0 array, 1 status, 2 identification, 3 query |
| rd_size | input | 2 | Access size: 0 one byte, 1 two, 2 four, 3 eight |
| rd_addr | input | ADDR_W | Byte address inside the device |
| status_byte | input | 8 | Current status register value |
| lock_bits | input | NBLK | Lock flag of each 64 KiB erase block |
| mem_req | output | 1 | Read strobe to the array memory |
| mem_addr | output | ADDR_W | Byte address to the array memory |
| mem_rdata | input | 64 | Array data, valid the cycle after mem_req |
| rd_valid | output | 1 | Response valid |
| rd_data | output | 64 | Response data |

## Verification
The bench builds the block with its default 2 MiB device, giving 32 erase blocks, so the computed geometry bytes are 0x14, 0x1F, 0x00, 0x80 and 0x00 and the lock vector has enough blocks for one locked block to sit between unlocked neighbours. A 2 MiB address space also lets the bench hit the identification aliasing, where an address with bits above bit 10 set still lands on the lock entry, and reach query indexes beyond the table end.

// File: rtl/flashq_pkg.sv
package flashq_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2,
    MODE_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } rd_size_e;

  localparam int CHIPS       = 2;
  localparam int ERASE_BYTES = 65536;
  localparam int BUF_LOG2    = 7;
  localparam int QTAB_END    = 'h44;

  // log2 of the bytes one chip holds
  function automatic logic [7:0] chip_size_log2(input int dev_bytes);
    return 8'($clog2(dev_bytes / CHIPS));
  endfunction

  // number of effective erase blocks, minus one
  function automatic logic [15:0] erase_count_m1(input int dev_bytes);
    return 16'((dev_bytes / ERASE_BYTES) - 1);
  endfunction

  // per-chip erase block size in units of 256 bytes
  function automatic logic [15:0] chip_block_units();
    return 16'((ERASE_BYTES / CHIPS) / 256);
  endfunction

  // constant part of the query table
  function automatic logic [7:0] fixed_query_byte(input logic [7:0] idx);
    case (idx)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h01;
      8'h15: return 8'h31;
      8'h1B: return 8'h45;
      8'h1C: return 8'h55;
      8'h1F: return 8'h01;
      8'h20: return 8'h01;
      8'h21: return 8'h01;
      8'h28: return 8'h05;
      8'h2A: return 8'(BUF_LOG2 + 1 - CHIPS);
      8'h2C: return 8'h01;
      8'h31: return 8'h50;
      8'h32: return 8'h52;
      8'h33: return 8'h49;
      8'h34: return 8'h31;
      8'h35: return 8'h30;
      8'h36: return 8'hA0;
      8'h3B: return 8'h01;
      8'h3D: return 8'h50;
      8'h3F: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // place a 16-bit answer on the bus lanes
  function automatic logic [63:0] pack_answer(input rd_size_e sz, input logic [15:0] v);
    case (sz)
      SZ_B1:   return {56'h0, v[7:0]};
      SZ_B2:   return {48'h0, v};
      default: return {32'h0, v, v};
    endcase
  endfunction

  // byte lanes covered by an access size
  function automatic logic [63:0] size_mask(input rd_size_e sz);
    case (sz)
      SZ_B1:   return 64'h0000_0000_0000_00FF;
      SZ_B2:   return 64'h0000_0000_0000_FFFF;
      SZ_B4:   return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/flashq_query_rom.sv
module flashq_query_rom
  import flashq_pkg::*;
#(
  parameter int DEV_BYTES = 2097152,
  parameter int IDX_W     = 19
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       qbyte
);

  localparam logic [7:0]  GEO_SIZE  = chip_size_log2(DEV_BYTES);
  localparam logic [15:0] GEO_COUNT = erase_count_m1(DEV_BYTES);
  localparam logic [15:0] GEO_UNITS = chip_block_units();

  logic in_table;
  assign in_table = (idx < IDX_W'(QTAB_END));

  always_comb begin
    qbyte = 8'h00;
    if (in_table) begin
      case (idx[7:0])
        8'h27:   qbyte = GEO_SIZE;
        8'h2D:   qbyte = GEO_COUNT[7:0];
        8'h2E:   qbyte = GEO_COUNT[15:8];
        8'h2F:   qbyte = GEO_UNITS[7:0];
        8'h30:   qbyte = GEO_UNITS[15:8];
        default: qbyte = fixed_query_byte(idx[7:0]);
      endcase
    end
  end

endmodule

// File: rtl/flashq_id_decode.sv
module flashq_id_decode #(
  parameter int ADDR_W = 21,
  parameter int NBLK   = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBLK-1:0]   lock_bits,
  output logic [15:0]       id_word
);

  localparam int BLK_W = ADDR_W - 16;

  logic [8:0]       entry;
  logic [BLK_W-1:0] blk;

  assign entry = addr[10:2];
  assign blk   = addr[ADDR_W-1:16];

  always_comb begin
    case (entry)
      9'd0:    id_word = 16'h0000;
      9'd1:    id_word = 16'hFFFF;
      9'd2:    id_word = {15'h0, lock_bits[blk]};
      default: id_word = 16'h0000;
    endcase
  end

endmodule

// File: rtl/flashq_lane_pack.sv
module flashq_lane_pack
  import flashq_pkg::*;
(
  input  logic        valid_q,
  input  rd_mode_e    mode_q,
  input  rd_size_e    size_q,
  input  logic [15:0] val_q,
  input  logic [63:0] mem_rdata,
  output logic [63:0] rd_data
);

  always_comb begin
    if (!valid_q)
      rd_data = 64'h0;
    else if (mode_q == MODE_ARRAY)
      rd_data = mem_rdata & size_mask(size_q);
    else
      rd_data = pack_answer(size_q, val_q);
  end

endmodule

// File: rtl/flashq_read_port.sv
module flashq_read_port
  import flashq_pkg::*;
#(
  parameter int DEV_BYTES = 2097152,
  localparam int ADDR_W   = $clog2(DEV_BYTES),
  localparam int NBLK     = DEV_BYTES / 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [1:0]        rd_mode,
  input  logic [1:0]        rd_size,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        status_byte,
  input  logic [NBLK-1:0]   lock_bits,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [63:0]       mem_rdata,
  output logic              rd_valid,
  output logic [63:0]       rd_data
);

  localparam int IDX_W = ADDR_W - 2;

  rd_mode_e        mode_in;
  rd_size_e        size_in;
  logic [7:0]      qbyte;
  logic [15:0]     id_word;
  logic [15:0]     answer;
  logic [IDX_W-1:0] qidx;

  logic            valid_q;
  rd_mode_e        mode_q;
  rd_size_e        size_q;
  logic [15:0]     val_q;

  // named events for the assertions
  logic            array_beat;
  logic            answer_beat;

  assign mode_in = rd_mode_e'(rd_mode);
  assign size_in = rd_size_e'(rd_size);
  assign qidx    = rd_addr[ADDR_W-1:2];

  flashq_query_rom #(.DEV_BYTES(DEV_BYTES), .IDX_W(IDX_W)) u_rom (
    .idx   (qidx),
    .qbyte (qbyte)
  );

  flashq_id_decode #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_id (
    .addr      (rd_addr),
    .lock_bits (lock_bits),
    .id_word   (id_word)
  );

  always_comb begin
    case (mode_in)
      MODE_STATUS: answer = {8'h00, status_byte};
      MODE_IDENT:  answer = id_word;
      MODE_QUERY:  answer = {8'h00, qbyte};
      default:     answer = 16'h0000;
    endcase
  end

  assign mem_req  = rd_req && (mode_in == MODE_ARRAY);
  assign mem_addr = rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mode_q  <= MODE_ARRAY;
      size_q  <= SZ_B1;
      val_q   <= 16'h0;
    end else begin
      valid_q <= rd_req;
      if (rd_req) begin
        mode_q <= mode_in;
        size_q <= size_in;
        val_q  <= answer;
      end
    end
  end

  flashq_lane_pack u_pack (
    .valid_q   (valid_q),
    .mode_q    (mode_q),
    .size_q    (size_q),
    .val_q     (val_q),
    .mem_rdata (mem_rdata),
    .rd_data   (rd_data)
  );

  assign rd_valid    = valid_q;
  assign array_beat  = valid_q && (mode_q == MODE_ARRAY);
  assign answer_beat = valid_q && (mode_q != MODE_ARRAY);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 64'h0); // R1
  AST_REQ_GIVES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R2
  AST_NO_SPURIOUS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid); // R2
  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    array_beat && size_q == SZ_B8 |-> rd_data == mem_rdata); // R3
  AST_NO_MEM_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> array_beat); // R3
  AST_QUERY_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && mode_in == MODE_QUERY && qidx >= IDX_W'(QTAB_END) |=> rd_data[15:0] == 16'h0); // R5
  AST_DEVICE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && mode_in == MODE_IDENT && rd_addr[10:2] == 9'd1 && size_in != SZ_B1
    |=> rd_data[15:0] == 16'hFFFF); // R7
  AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    answer_beat && (size_q == SZ_B4 || size_q == SZ_B8) |-> rd_data[31:16] == rd_data[15:0]); // R8
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    answer_beat |-> rd_data[63:32] == 32'h0); // R8
  AST_HOLD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    answer_beat && !rd_req |=> $stable(val_q)); // R9

endmodule

// File: tb/tb_flashq_read_port.sv
module tb_flashq_read_port;

  localparam int CLK_PERIOD = 10;
  localparam int DEV_BYTES  = 2097152;
  localparam int AW         = 21;
  localparam int NB         = 32;
  localparam int NVEC       = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req = 1'b0;
  logic [1:0]    rd_mode = 2'd0;
  logic [1:0]    rd_size = 2'd0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    status_byte = 8'h80;
  logic [NB-1:0] lock_bits = 32'h0000_0004;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_rdata = 64'h0;
  logic          rd_valid;
  logic [63:0]   rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flashq_read_port #(.DEV_BYTES(DEV_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_mode(rd_mode),
    .rd_size(rd_size), .rd_addr(rd_addr), .status_byte(status_byte),
    .lock_bits(lock_bits), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // synchronous array memory model with an address-derived pattern
  always @(posedge clk)
    if (mem_req) mem_rdata <= {32'hA5A5_0000 ^ 32'(mem_addr), 32'(mem_addr)};

  // {mode, size, addr, expected}; lock_bits = block 2 locked, status 0x80
  localparam logic [88:0] VEC [NVEC] = '{
    {2'd3, 2'd2, 21'h00040, 64'h0000_0000_0051_0051}, // R5 'Q'
    {2'd3, 2'd0, 21'h00044, 64'h0000_0000_0000_0052}, // R5 'R' byte
    {2'd3, 2'd1, 21'h00048, 64'h0000_0000_0000_0059}, // R5 'Y' half
    {2'd3, 2'd2, 21'h0004C, 64'h0000_0000_0001_0001}, // R5
    {2'd3, 2'd2, 21'h000A8, 64'h0000_0000_0006_0006}, // R5
    {2'd3, 2'd3, 21'h000C4, 64'h0000_0000_0050_0050}, // R5 'P' 8-byte
    {2'd3, 2'd0, 21'h000C8, 64'h0000_0000_0000_0052}, // R5
    {2'd3, 2'd0, 21'h000CC, 64'h0000_0000_0000_0049}, // R5 'I'
    {2'd3, 2'd2, 21'h00110, 64'h0},                   // R5 first past end
    {2'd3, 2'd2, 21'h1FFFC, 64'h0},                   // R5 far past end
    {2'd3, 2'd2, 21'h0009C, 64'h0000_0000_0014_0014}, // R6 size exp
    {2'd3, 2'd2, 21'h000B4, 64'h0000_0000_001F_001F}, // R6 count lo
    {2'd3, 2'd2, 21'h000B8, 64'h0},                   // R6 count hi
    {2'd3, 2'd2, 21'h000BC, 64'h0000_0000_0080_0080}, // R6 units lo
    {2'd3, 2'd2, 21'h000C0, 64'h0},                   // R6 units hi
    {2'd2, 2'd2, 21'h00000, 64'h0},                   // R7 vendor
    {2'd2, 2'd2, 21'h00004, 64'h0000_0000_FFFF_FFFF}, // R7 device
    {2'd2, 2'd0, 21'h00004, 64'h0000_0000_0000_00FF}, // R8 byte
    {2'd2, 2'd3, 21'h00004, 64'h0000_0000_FFFF_FFFF}, // R8 8-byte
    {2'd2, 2'd1, 21'h20008, 64'h0000_0000_0000_0001}, // R7 locked block
    {2'd2, 2'd2, 21'h10008, 64'h0},                   // R7 unlocked block
    {2'd2, 2'd2, 21'h20808, 64'h0000_0000_0001_0001}, // R7 alias of entry 2
    {2'd2, 2'd2, 21'h3000C, 64'h0},                   // R7 entry 3
    {2'd1, 2'd2, 21'h01234, 64'h0000_0000_0080_0080}, // R4
    {2'd1, 2'd0, 21'h00000, 64'h0000_0000_0000_0080}, // R4
    {2'd1, 2'd3, 21'h00010, 64'h0000_0000_0080_0080}, // R4
    {2'd0, 2'd3, 21'h00123, 64'hA5A5_0123_0000_0123}, // R3 8-byte
    {2'd0, 2'd1, 21'h00456, 64'h0000_0000_0000_0456}, // R3 2-byte
    {2'd0, 2'd2, 21'h1F000, 64'h0000_0000_0001_F000}, // R3 4-byte
    {2'd0, 2'd0, 21'h1ABCD, 64'h0000_0000_0000_00CD}  // R3 1-byte
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one request, response sampled at the following falling edge
  task automatic do_read(input logic [1:0] m, input logic [1:0] s, input logic [AW-1:0] a);
    @(negedge clk);
    rd_req = 1'b1; rd_mode = m; rd_size = s; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(rd_valid), 64'h0);
    check("R1 reset data", rd_data, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle data", rd_data, 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      do_read(VEC[i][88:87], VEC[i][86:85], VEC[i][84:64]);
      check("R2 valid", 64'(rd_valid), 64'h1);
      check($sformatf("R3-R8 vector %0d", i), rd_data, VEC[i][63:0]);
    end

    // R2: no beat without a request
    @(negedge clk);
    check("R2 no spurious valid", 64'(rd_valid), 64'h0);
    check("R1 data zero when idle", rd_data, 64'h0);

    // R3: no memory strobe outside array mode
    @(negedge clk);
    rd_req = 1'b1; rd_mode = 2'd3; rd_addr = 21'h40;
    #1 check("R3 mem_req low in query mode", 64'(mem_req), 64'h0);
    rd_mode = 2'd0; rd_addr = 21'h0777;
    #1 check("R3 mem_req high in array mode", 64'(mem_req), 64'h1);
    check("R3 mem_addr", 64'(mem_addr), 64'h777);
    rd_mode = 2'd3; rd_addr = 21'h40;
    @(negedge clk);
    rd_req = 1'b0;

    // R4: a new status value is reported
    status_byte = 8'h9A;
    do_read(2'd1, 2'd2, 21'h0);
    check("R4 status 0x9A", rd_data, 64'h0000_0000_009A_009A);

    // R9: inputs changed after the request edge leave the answer intact
    @(negedge clk);
    rd_req = 1'b1; rd_mode = 2'd2; rd_size = 2'd2; rd_addr = 21'h20008;
    @(negedge clk);
    rd_req = 1'b0; rd_mode = 2'd1; rd_addr = 21'h0; lock_bits = '0; status_byte = 8'h00;
    #1 check("R9 lock answer held", rd_data, 64'h0000_0000_0001_0001);
    @(negedge clk);
    check("R9 lock bit now clear", 64'(rd_valid), 64'h0);
    do_read(2'd2, 2'd2, 21'h20008);
    check("R7 cleared lock read", rd_data, 64'h0);

    // R2: back-to-back requests each give one beat
    @(negedge clk);
    rd_req = 1'b1; rd_mode = 2'd2; rd_size = 2'd1; rd_addr = 21'h4;
    @(negedge clk);
    check("R2 back-to-back beat 1", rd_data, 64'h0000_0000_0000_FFFF);
    rd_addr = 21'h0;
    @(negedge clk);
    rd_req = 1'b0;
    check("R2 back-to-back beat 2", rd_data, 64'h0);
    check("R2 back-to-back valid", 64'(rd_valid), 64'h1);
    @(negedge clk);
    check("R2 beat ends", 64'(rd_valid), 64'h0);

    // R1: reset mid-stream clears the response
    @(negedge clk);
    rd_req = 1'b1; rd_mode = 2'd2; rd_size = 2'd2; rd_addr = 21'h4;
    @(negedge clk);
    rd_req = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears valid", 64'(rd_valid), 64'h0);
    check("R1 reset clears data", rd_data, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule